// File: doc/BRIEF.md
# Conversion Readout Sequencer

This block drives one complete sampling cycle of an eight-channel simultaneous-sampling converter that has a 16-bit parallel data bus. A start request makes it pulse the active-low convert line for a set number of clock cycles. It then waits for the converter's busy line to rise and fall again. After that it pulls chip select low and issues one active-low read strobe for every bus word in the frame. Each strobe has a low time and a high time set by parameters.

The number of words in a frame depends on three options, sampled when the conversion is started:
- wide samples (two words per channel);
- a per-channel status word;
- a trailing CRC word.

Every word read is presented raw, with its index within the frame. A first-word flag marks the period in which channel 1's leading word is on the bus. Sample assembly, host registers and DMA are left to neighbouring blocks.

A start request that arrives while a cycle is already in progress is not acted on. It sets a sticky overrun flag, which only reset clears.

Top module: `adc_conv_readout`

## Requirements
- R1: After reset, conv_n, cs_n and rd_n are high, and overrun and word_valid are low.
- R2: A start request seen while idle drives conv_n low, starting in the next cycle, for exactly CONV_LOW cycles.
- R3: cs_n stays high until busy has risen and then fallen after the convert pulse. No read strobe occurs while busy is high.
- R4: The frame holds 8*(1+wide+status)+crc read strobes, where each option counts 1 when enabled and 0 otherwise. cs_n stays low from the first strobe until after the last. frame_done pulses exactly once per frame.
- R5: Each read strobe is low for exactly RD_LOW cycles. Consecutive strobes are separated by RD_HIGH high cycles.
- R6: The bus value present in the last low cycle of a strobe appears on word_data one cycle later, with word_valid high for one cycle. word_idx counts 0, 1, 2 and so on, in strobe order.
- R7: first_word is high from the first strobe until the second strobe begins. It is low at every other time.
- R8: A start request while a cycle is in progress starts no new conversion. It sets overrun, which stays high until reset.
- R9: The options are captured when the conversion starts. Changing them during a frame does not alter that frame's word count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_req | input | 1 | Request one sampling cycle |
| opt_wide | input | 1 | Two bus words per channel |
| opt_status | input | 1 | Extra status word per channel |
| opt_crc | input | 1 | One trailing CRC word |
| busy_i | input | 1 | Converter busy, active high |
| bus_i | input | 16 | Parallel data bus from the converter |
| conv_n | output | 1 | Active-low convert pulse |
| cs_n | output | 1 | Active-low chip select |
| rd_n | output | 1 | Active-low read strobe |
| word_valid | output | 1 | One-cycle pulse, new word on word_data |
| word_data | output | 16 | Captured raw bus word |
| word_idx | output | IDX_W (5) | Index of the captured word within the frame |
| first_word | output | 1 | High during the first word of the frame |
| frame_done | output | 1 | Pulse on the final cycle of a frame |
| overrun | output | 1 | Sticky: a start request was refused |

## Verification
The assertions assume that the converter behaves: busy is never high while chip select is low, and the start request lasts a single cycle. The bench's converter model raises busy only in response to the end of the convert pulse, holds it for a fixed number of cycles, and drops it before any read can begin. Start requests are always one-cycle pulses driven between clock edges. The bus model places a fresh pattern, tagged with the frame and strobe number, on each falling strobe. Every captured word can therefore be traced back to the exact strobe that produced it.

// File: rtl/cvr_pkg.sv
`timescale 1ns/1ps
package cvr_pkg;
   typedef enum logic [2:0] {
      S_IDLE  = 3'd0,
      S_CONV  = 3'd1,
      S_WRISE = 3'd2,
      S_WFALL = 3'd3,
      S_READ  = 3'd4
   } cvr_state_t;

   typedef struct packed {
      logic wide;
      logic stat;
      logic crc;
   } cvr_opts_t;
endpackage

// File: rtl/cvr_strobe_gen.sv
`timescale 1ns/1ps
module cvr_strobe_gen #(
   parameter int RD_LOW  = 2,
   parameter int RD_HIGH = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic rd_n,
   output logic cap,
   output logic wend
);
   localparam int MAXPH = (RD_LOW > RD_HIGH) ? RD_LOW : RD_HIGH;
   localparam int CW    = $clog2(MAXPH + 1);

   logic          low_ph;
   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_ph <= 1'b1;
         cnt    <= '0;
      end else if (!en) begin
         low_ph <= 1'b1;
         cnt    <= '0;
      end else if (low_ph) begin
         if (cnt == CW'(RD_LOW - 1)) begin
            low_ph <= 1'b0;
            cnt    <= '0;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end else begin
         if (cnt == CW'(RD_HIGH - 1)) begin
            low_ph <= 1'b1;
            cnt    <= '0;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   assign rd_n = !(en && low_ph);
   assign cap  = en && low_ph && (cnt == CW'(RD_LOW - 1));
   assign wend = en && !low_ph && (cnt == CW'(RD_HIGH - 1));

   // R5: the strobe only rises after a full low phase that ended in a capture
   a_r5_low_width: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_n) |-> $past(cap));
endmodule

// File: rtl/cvr_word_counter.sv
`timescale 1ns/1ps
module cvr_word_counter #(
   parameter int IDX_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   output logic [IDX_W-1:0] idx
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   idx <= '0;
      else if (clr) idx <= '0;
      else if (inc) idx <= idx + 1'b1;
   end
endmodule

// File: rtl/adc_conv_readout.sv
`timescale 1ns/1ps
module adc_conv_readout #(
   parameter int N_CH     = 8,
   parameter int BUS_W    = 16,
   parameter int CONV_LOW = 3,
   parameter int RD_LOW   = 2,
   parameter int RD_HIGH  = 2,
   parameter int IDX_W    = $clog2(3 * N_CH + 2)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_req,
   input  logic             opt_wide,
   input  logic             opt_status,
   input  logic             opt_crc,
   input  logic             busy_i,
   input  logic [BUS_W-1:0] bus_i,
   output logic             conv_n,
   output logic             cs_n,
   output logic             rd_n,
   output logic             word_valid,
   output logic [BUS_W-1:0] word_data,
   output logic [IDX_W-1:0] word_idx,
   output logic             first_word,
   output logic             frame_done,
   output logic             overrun
);
   import cvr_pkg::*;

   localparam int CCW = $clog2(CONV_LOW + 1);

   generate
      if (RD_LOW < 1 || RD_HIGH < 1) begin : g_bad_strobe
         $error("strobe phases need at least one cycle each");
      end
      if (CONV_LOW < 1) begin : g_bad_conv
         $error("convert pulse needs at least one cycle");
      end
      if (N_CH < 1 || (3 * N_CH + 1) >= (1 << IDX_W)) begin : g_bad_idx
         $error("IDX_W too narrow for the longest frame");
      end
   endgenerate

   cvr_state_t       state;
   cvr_opts_t        opts;
   logic [CCW-1:0]   ccnt;
   logic [IDX_W-1:0] idx;
   logic [IDX_W-1:0] total;
   logic             rd_en, cap, wend, last_end;

   always_comb begin
      total = IDX_W'(N_CH)
            + (opts.wide ? IDX_W'(N_CH) : '0)
            + (opts.stat ? IDX_W'(N_CH) : '0)
            + IDX_W'(opts.crc);
   end

   assign rd_en    = (state == S_READ);
   assign last_end = wend && (idx == total - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= S_IDLE;
         opts    <= '0;
         ccnt    <= '0;
         overrun <= 1'b0;
      end else begin
         if (start_req && state != S_IDLE) overrun <= 1'b1;
         unique case (state)
            S_IDLE: if (start_req) begin
               state <= S_CONV;
               ccnt  <= '0;
               opts  <= '{wide: opt_wide, stat: opt_status, crc: opt_crc};
            end
            S_CONV: begin
               if (ccnt == CCW'(CONV_LOW - 1)) state <= S_WRISE;
               else                            ccnt  <= ccnt + 1'b1;
            end
            S_WRISE: if (busy_i)  state <= S_WFALL;
            S_WFALL: if (!busy_i) state <= S_READ;
            S_READ:  if (last_end) state <= S_IDLE;
            default: state <= S_IDLE;
         endcase
      end
   end

   cvr_strobe_gen #(.RD_LOW(RD_LOW), .RD_HIGH(RD_HIGH)) u_strobe (
      .clk(clk), .rst_n(rst_n), .en(rd_en), .rd_n(rd_n), .cap(cap), .wend(wend));

   cvr_word_counter #(.IDX_W(IDX_W)) u_count (
      .clk(clk), .rst_n(rst_n), .clr(!rd_en), .inc(wend), .idx(idx));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_valid <= 1'b0;
         word_data  <= '0;
         word_idx   <= '0;
      end else begin
         word_valid <= cap;
         if (cap) begin
            word_data <= bus_i;
            word_idx  <= idx;
         end
      end
   end

   assign conv_n     = (state != S_CONV);
   assign cs_n       = !rd_en;
   assign first_word = rd_en && (idx == '0);
   assign frame_done = rd_en && last_end;

   // R2: convert pulse only begins in answer to a request
   a_r2_conv_on_request: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(conv_n) |-> $past(start_req));
   // R3: chip select never low while the converter reports busy
   a_r3_no_cs_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
      busy_i |-> cs_n);
   // R4: the word counter stays inside the configured frame
   a_r4_idx_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_n |-> (idx < total));
   // R6: one valid pulse per captured word
   a_r6_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
      word_valid |=> !word_valid);
   // R8: overrun is sticky
   a_r8_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      overrun |=> overrun);
   // R5: read strobes only under chip select
   a_r5_rd_under_cs: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_n |-> !cs_n);
endmodule

// File: tb/adc_conv_readout_test.sv
`timescale 1ns/1ps
module adc_conv_readout_test;
   localparam int CONV_LOW = 3;
   localparam int RD_LOW   = 2;
   localparam int RD_HIGH  = 2;
   localparam int BUSY_CYC = 6;
   localparam int IDX_W    = 5;

   // {wide, status, crc, expected word count}
   localparam logic [7:0] VEC [8] = '{
      {3'b000, 5'd8},  {3'b001, 5'd9},  {3'b010, 5'd16}, {3'b011, 5'd17},
      {3'b100, 5'd16}, {3'b101, 5'd17}, {3'b110, 5'd24}, {3'b111, 5'd25}};

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic rst_n = 1'b0, start_req = 1'b0;
   logic opt_wide = 1'b0, opt_status = 1'b0, opt_crc = 1'b0, busy_i = 1'b0;
   logic [15:0] bus_i = '0;
   logic conv_n, cs_n, rd_n, word_valid, first_word, frame_done, overrun;
   logic [15:0] word_data;
   logic [IDX_W-1:0] word_idx;

   adc_conv_readout #(.CONV_LOW(CONV_LOW), .RD_LOW(RD_LOW), .RD_HIGH(RD_HIGH),
                      .IDX_W(IDX_W)) uut (
      .clk(clk), .rst_n(rst_n), .start_req(start_req), .opt_wide(opt_wide),
      .opt_status(opt_status), .opt_crc(opt_crc), .busy_i(busy_i), .bus_i(bus_i),
      .conv_n(conv_n), .cs_n(cs_n), .rd_n(rd_n), .word_valid(word_valid),
      .word_data(word_data), .word_idx(word_idx), .first_word(first_word),
      .frame_done(frame_done), .overrun(overrun));

   int n_checks = 0, n_fail = 0;
   int fr = 0, rcount = 0, wcount = 0, lowrun = 0, convrun = 0, bcnt = 0;
   int data_err = 0, idx_err = 0, first_err = 0, busy_cs_err = 0, low_err = 0;
   int conv_w_err = 0, conv_falls = 0, done_cnt = 0;
   logic prev_rd = 1'b1, prev_conv = 1'b1;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // converter and bus model plus monitors, all on the falling edge
   initial forever begin
      @(negedge clk);
      if (!rst_n) begin
         busy_i = 1'b0; bcnt = 0; prev_rd = 1'b1; prev_conv = 1'b1;
         lowrun = 0; convrun = 0;
      end else begin
         if (!conv_n) convrun++;
         if (!conv_n && prev_conv) begin
            conv_falls++; fr++; rcount = 0; wcount = 0;
         end
         if (conv_n && !prev_conv) begin
            if (convrun != CONV_LOW) conv_w_err++;
            convrun = 0; bcnt = 1;
         end
         if (bcnt > 0) begin
            busy_i = (bcnt <= BUSY_CYC);
            bcnt = (bcnt > BUSY_CYC) ? 0 : bcnt + 1;
         end
         if (busy_i && !cs_n) busy_cs_err++;
         if (!rd_n) begin
            if (busy_i) busy_cs_err++;
            lowrun++;
            if (prev_rd) begin
               rcount++;
               bus_i = 16'h5A00 ^ {fr[7:0], rcount[7:0]};
            end
         end else if (!prev_rd) begin
            if (lowrun != RD_LOW) low_err++;
            lowrun = 0;
         end
         if (first_word != (!cs_n && rcount == 1)) first_err++;
         if (word_valid) begin
            if (word_data != (16'h5A00 ^ {fr[7:0], 8'(wcount + 1)})) data_err++;
            if (int'(word_idx) != wcount) idx_err++;
            wcount++;
         end
         if (frame_done) done_cnt++;
         prev_rd = rd_n; prev_conv = conv_n;
      end
   end

   task automatic clear_errs();
      data_err = 0; idx_err = 0; first_err = 0; busy_cs_err = 0;
      low_err = 0; conv_w_err = 0;
   endtask

   task automatic start_frame(input logic w, input logic s, input logic c);
      @(negedge clk);
      opt_wide = w; opt_status = s; opt_crc = c; start_req = 1'b1;
      @(negedge clk);
      start_req = 1'b0;
   endtask

   task automatic wait_done(input int d0);
      for (int k = 0; k < 3000 && done_cnt == d0; k++) @(negedge clk);
      repeat (4) @(negedge clk);
   endtask

   task automatic wait_cs_low();
      for (int k = 0; k < 3000 && cs_n; k++) @(negedge clk);
   endtask

   task automatic frame_checks(input int exp, input int d0);
      chk(wcount == exp, "R4 word count", wcount, exp);
      chk(done_cnt == d0 + 1, "R4 frame_done pulses", done_cnt - d0, 1);
      chk(data_err == 0, "R6 captured data", data_err, 0);
      chk(idx_err == 0, "R6 word index", idx_err, 0);
      chk(first_err == 0, "R7 first_word", first_err, 0);
      chk(low_err == 0, "R5 strobe low width", low_err, 0);
      chk(busy_cs_err == 0, "R3 read during busy", busy_cs_err, 0);
      chk(conv_w_err == 0, "R2 convert width", conv_w_err, 0);
   endtask

   task automatic reset_checks();
      chk(conv_n && cs_n && rd_n, "R1 strobes high", {conv_n, cs_n, rd_n}, 7);
      chk(!overrun, "R1 overrun low", overrun, 0);
      chk(!word_valid, "R1 word_valid low", word_valid, 0);
   endtask

   bit finished = 1'b0;

   initial begin
      #(200000 * 5);
      if (!finished) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      int d0, f0;
      repeat (3) @(negedge clk);
      reset_checks();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // table of option settings and expected word counts
      for (int i = 0; i < 8; i++) begin
         clear_errs(); d0 = done_cnt;
         start_frame(VEC[i][7], VEC[i][6], VEC[i][5]);
         wait_done(d0);
         frame_checks(int'(VEC[i][4:0]), d0);
      end

      // R8: request during readout is refused and flagged
      clear_errs(); d0 = done_cnt; f0 = conv_falls;
      start_frame(1'b1, 1'b1, 1'b1);
      wait_cs_low();
      start_req = 1'b1; @(negedge clk); start_req = 1'b0;
      @(negedge clk);
      chk(overrun, "R8 overrun set", overrun, 1);
      wait_done(d0);
      chk(conv_falls == f0 + 1, "R8 no extra conversion", conv_falls - f0, 1);
      frame_checks(25, d0);

      // R8: request during the busy wait is also refused
      d0 = done_cnt; f0 = conv_falls;
      start_frame(1'b0, 1'b0, 1'b0);
      repeat (CONV_LOW + 2) @(negedge clk);
      start_req = 1'b1; @(negedge clk); start_req = 1'b0;
      wait_done(d0);
      chk(conv_falls == f0 + 1, "R8 refused in busy wait", conv_falls - f0, 1);
      chk(overrun, "R8 overrun still set", overrun, 1);

      // R9: options changed mid-frame have no effect on the frame
      clear_errs(); d0 = done_cnt;
      start_frame(1'b0, 1'b0, 1'b0);
      wait_cs_low();
      opt_wide = 1'b1; opt_status = 1'b1; opt_crc = 1'b1;
      wait_done(d0);
      chk(wcount == 8, "R9 options latched at start", wcount, 8);
      frame_checks(8, d0);

      // R1: reset clears the sticky flag
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      reset_checks();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule